// File: doc/BRIEF.md
# Pin Edge-Detect Interrupt Unit

This block turns the raw input levels of a port of pins into per-pin events and interrupt flags. Each pin first crosses into the clock domain through a short synchronizer. An optional glitch filter can then reject pulses that are too short. An edge detector watches the result and fires on any change, on rising edges only or on falling edges only. Every detected edge produces a one-cycle event pulse and sets a sticky per-pin flag. The flags are combined with per-pin enable bits into a single interrupt line.

All per-pin configuration (filter enable, interrupt enable and the two mode bits) lives in flops. Each flop is changed only through one-hot write-one-to-set and write-one-to-clear strobe vectors, so a bus decoder can drive them with single-cycle pulses. Flags are cleared with their own write-one-to-clear strobe vector. The bus decoder and the pad logic sit outside this block.

Top module: `pin_evt_top`

## Requirements
- R1: After reset every flag is 0, the interrupt line is 0, no event pulse is active, and every pin has filter off, interrupt disabled and mode code 00.
- R2: With the filter off, a level change applied before clock edge k shows as an event pulse in the cycle after edge k+1 and sets the flag at edge k+2 (two synchronizer stages).
- R3: The mode code of a pin is {modeHi, modeLo}: 00 fires on any change, 01 only on rising edges, 10 only on falling edges, and 11 never fires.
- R4: With the filter on, a new synchronized level reaches the detector only once it has been sampled equal on two consecutive clocks. This adds two cycles of latency, and a level that lasts a single sample is dropped.
- R5: The mode code works the same with the filter on or off.
- R6: A detected edge sets the pin's flag, and the flag stays set until a 1 is written to that bit of flagClr. If an edge and a clear hit the same cycle, the flag stays set.
- R7: The event pulse of a pin is one cycle long for each detected edge, whether or not its interrupt is enabled, and a flag with its enable clear does not raise irq.
- R8: irq is high exactly when some pin has both its flag and its interrupt enable set. The enable takes effect one cycle after its set strobe.
- R9: The set and clear strobes change only the bits written as 1. When set and clear of the same bit come in the same cycle, clear wins.
- R10: After reset, the detector takes its first reference level from the first synchronized sample, so a pin held high through reset gives no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw pin levels, asynchronous |
| filtSet | input | NUM_PINS | Write-one-to-set glitch filter enable |
| filtClr | input | NUM_PINS | Write-one-to-clear glitch filter enable |
| intEnSet | input | NUM_PINS | Write-one-to-set interrupt enable |
| intEnClr | input | NUM_PINS | Write-one-to-clear interrupt enable |
| modeLoSet | input | NUM_PINS | Write-one-to-set low mode bit |
| modeLoClr | input | NUM_PINS | Write-one-to-clear low mode bit |
| modeHiSet | input | NUM_PINS | Write-one-to-set high mode bit |
| modeHiClr | input | NUM_PINS | Write-one-to-clear high mode bit |
| flagClr | input | NUM_PINS | Write-one-to-clear interrupt flags |
| flags | output | NUM_PINS | Sticky per-pin interrupt flags |
| irq | output | 1 | OR of flag AND enable over all pins |
| evtPulse | output | NUM_PINS | One-cycle pulse per detected edge |

## Verification
The bench aims at a pin held high through reset, which a detector with a zeroed reference level would report as a false rising edge. It sends one-sample glitches through the filter, which a filter that passed a level after one sample would turn into flags, and it checks the exact latency in both filter settings to catch a missing or extra stage. It puts a flag clear in the same cycle as a new edge, which a clear-wins flag would lose, and it writes set and clear of one enable together, where the wrong priority leaves irq high. A random phase with a cycle-by-cycle model covers the reserved mode and the rise-only and fall-only modes, where a swapped mode bit fires on the wrong edge.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  // Per-pin control bundle handed from the control side to the datapath
  typedef struct packed {
    logic filtEn;
    logic modeHi;
    logic modeLo;
    logic flagClr;
  } pinCtl_t;

  // Edge mode code {modeHi, modeLo}
  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RISE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_NONE = 2'b11
  } edgeMode_e;

endpackage

// File: rtl/pin_evt_ctrl.sv
module pin_evt_ctrl
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] filtSet,
  input  logic [NUM_PINS-1:0] filtClr,
  input  logic [NUM_PINS-1:0] intEnSet,
  input  logic [NUM_PINS-1:0] intEnClr,
  input  logic [NUM_PINS-1:0] modeLoSet,
  input  logic [NUM_PINS-1:0] modeLoClr,
  input  logic [NUM_PINS-1:0] modeHiSet,
  input  logic [NUM_PINS-1:0] modeHiClr,
  input  logic [NUM_PINS-1:0] flagClr,
  input  logic [NUM_PINS-1:0] flags,
  output pinCtl_t [NUM_PINS-1:0] ctl,
  output logic                irq
);

  logic [NUM_PINS-1:0] filtEnQ, intEnQ, modeLoQ, modeHiQ;

  // Clear has priority over set for the same bit
  function automatic logic [NUM_PINS-1:0] applySetClr(
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] setV,
    input logic [NUM_PINS-1:0] clrV
  );
    return (cur | setV) & ~clrV;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtEnQ <= '0;
      intEnQ  <= '0;
      modeLoQ <= '0;
      modeHiQ <= '0;
    end else begin
      filtEnQ <= applySetClr(filtEnQ, filtSet, filtClr);
      intEnQ  <= applySetClr(intEnQ, intEnSet, intEnClr);
      modeLoQ <= applySetClr(modeLoQ, modeLoSet, modeLoClr);
      modeHiQ <= applySetClr(modeHiQ, modeHiSet, modeHiClr);
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign ctl[i] = '{filtEn:  filtEnQ[i],
                      modeHi:  modeHiQ[i],
                      modeLo:  modeLoQ[i],
                      flagClr: flagClr[i]};
  end

  assign irq = |(flags & intEnQ);

  // R9: a bit cleared in the previous cycle is 0 now, even if it was also set
  p_filt_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (filtEnQ & $past(filtClr)) == '0);
  p_inten_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ & $past(intEnClr)) == '0);
  // R9: an enable bit rises only through its set strobe
  p_inten_rise_needs_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ & ~$past(intEnQ) & ~$past(intEnSet)) == '0);
  // R8: irq needs at least one flagged pin
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != '0));

endmodule

// File: rtl/pin_evt_datapath.sv
module pin_evt_datapath
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PINS-1:0]    pinIn,
  input  pinCtl_t [NUM_PINS-1:0] ctl,
  output logic [NUM_PINS-1:0]    flags,
  output logic [NUM_PINS-1:0]    evtPulse
);

  typedef logic [SYNC_STAGES-1:0] syncVec_t;
  localparam syncVec_t ONE_LSB = syncVec_t'(1);

  // Tracks how far valid data has travelled down the synchronizers
  syncVec_t vldQ;
  logic     armedQ;
  logic     sampleValid;

  assign sampleValid = vldQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ   <= '0;
      armedQ <= 1'b0;
    end else begin
      vldQ   <= (vldQ << 1) | ONE_LSB;
      armedQ <= sampleValid;
    end
  end

  logic [NUM_PINS-1:0] clrVec, sampledVec, prevVec, filtVec;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    syncVec_t syncQ;
    logic     sampled;
    logic     prevQ, filtQ, lastQ, flagQ;
    logic     level, changed, evt;

    assign sampled = syncQ[SYNC_STAGES-1];
    // Filtered level is used only once the filter has been seeded
    assign level   = (ctl[i].filtEn && armedQ) ? filtQ : sampled;
    assign changed = armedQ && (level != lastQ);

    always_comb begin
      unique case (edgeMode_e'({ctl[i].modeHi, ctl[i].modeLo}))
        MODE_ANY:  evt = changed;
        MODE_RISE: evt = changed && level;
        MODE_FALL: evt = changed && !level;
        default:   evt = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
        filtQ <= 1'b0;
        lastQ <= 1'b0;
        flagQ <= 1'b0;
      end else begin
        syncQ <= (syncQ << 1) | syncVec_t'(pinIn[i]);
        prevQ <= sampled;
        if (!armedQ || (sampled == prevQ)) filtQ <= sampled;
        lastQ <= level;
        // A new edge wins over a clear in the same cycle
        flagQ <= (flagQ & ~ctl[i].flagClr) | evt;
      end
    end

    assign flags[i]      = flagQ;
    assign evtPulse[i]   = evt;
    assign clrVec[i]     = ctl[i].flagClr;
    assign sampledVec[i] = sampled;
    assign prevVec[i]    = prevQ;
    assign filtVec[i]    = filtQ;

    // R3: reserved mode code never reports an edge
    p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[i].modeHi && ctl[i].modeLo) |-> !evtPulse[i]);
  end

  // R6: an event sets its flag at the next edge
  p_event_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flags & $past(evtPulse)) == $past(evtPulse));
  // R6: a flag rises only because of an event
  p_flag_from_event_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~$past(flags) & ~$past(evtPulse)) == '0);
  // R6: a flag falls only through its clear strobe
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (~flags & $past(flags) & ~$past(clrVec)) == '0);
  // R10: no event before the reference level is seeded
  p_no_early_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (evtPulse == '0));
  // R4: once running, the filter moves only to a level seen twice in a row
  p_filter_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(armedQ) |->
      (((filtVec ^ $past(filtVec)) & ($past(sampledVec) ^ $past(prevVec))) == '0));

endmodule

// File: rtl/pin_evt_top.sv
module pin_evt_top
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] filtSet,
  input  logic [NUM_PINS-1:0] filtClr,
  input  logic [NUM_PINS-1:0] intEnSet,
  input  logic [NUM_PINS-1:0] intEnClr,
  input  logic [NUM_PINS-1:0] modeLoSet,
  input  logic [NUM_PINS-1:0] modeLoClr,
  input  logic [NUM_PINS-1:0] modeHiSet,
  input  logic [NUM_PINS-1:0] modeHiClr,
  input  logic [NUM_PINS-1:0] flagClr,
  output logic [NUM_PINS-1:0] flags,
  output logic                irq,
  output logic [NUM_PINS-1:0] evtPulse
);

  pinCtl_t [NUM_PINS-1:0] pinCtl;

  pin_evt_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .filtSet   (filtSet),
    .filtClr   (filtClr),
    .intEnSet  (intEnSet),
    .intEnClr  (intEnClr),
    .modeLoSet (modeLoSet),
    .modeLoClr (modeLoClr),
    .modeHiSet (modeHiSet),
    .modeHiClr (modeHiClr),
    .flagClr   (flagClr),
    .flags     (flags),
    .ctl       (pinCtl),
    .irq       (irq)
  );

  pin_evt_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .ctl      (pinCtl),
    .flags    (flags),
    .evtPulse (evtPulse)
  );

endmodule

// File: tb/tb_pin_evt_top.sv
`timescale 1ns/1ps
module tb_pin_evt_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] pin = '0;
  logic [31:0] fSet = '0, fClr = '0, eSet = '0, eClr = '0;
  logic [31:0] loSet = '0, loClr = '0, hiSet = '0, hiClr = '0, fc = '0;
  logic [31:0] flags, evt;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit cmpOn = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pin_evt_top dut (
    .clk(clk), .rstN(rstN), .pinIn(pin),
    .filtSet(fSet), .filtClr(fClr), .intEnSet(eSet), .intEnClr(eClr),
    .modeLoSet(loSet), .modeLoClr(loClr), .modeHiSet(hiSet), .modeHiClr(hiClr),
    .flagClr(fc), .flags(flags), .irq(irq), .evtPulse(evt)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] mS1, mS2, mPrev, mFilt, mLast, mFlag, mGf, mIe, mLo, mHi;
  int mCnt;

  function automatic bit [31:0] mLevel();
    bit [31:0] r;
    for (int p = 0; p < 32; p++)
      r[p] = (mGf[p] && mCnt >= 3) ? mFilt[p] : mS2[p];
    return r;
  endfunction

  function automatic bit [31:0] mEvt();
    bit [31:0] r, lv;
    lv = mLevel();
    for (int p = 0; p < 32; p++) begin
      bit ch;
      ch = (mCnt >= 3) && (lv[p] != mLast[p]);
      case ({mHi[p], mLo[p]})
        2'b00:   r[p] = ch;
        2'b01:   r[p] = ch && lv[p];
        2'b10:   r[p] = ch && !lv[p];
        default: r[p] = 1'b0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mFilt = '0; mLast = '0; mFlag = '0;
      mGf = '0; mIe = '0; mLo = '0; mHi = '0; mCnt = 0;
    end else begin
      bit [31:0] ev, lv;
      ev = mEvt();
      lv = mLevel();
      for (int p = 0; p < 32; p++) begin
        mFlag[p] = (mFlag[p] && !fc[p]) || ev[p];
        if (mCnt < 3 || mS2[p] == mPrev[p]) mFilt[p] = mS2[p];
      end
      mPrev = mS2; mLast = lv; mS2 = mS1; mS1 = pin;
      if (mCnt < 3) mCnt++;
      mGf = (mGf | fSet) & ~fClr;
      mIe = (mIe | eSet) & ~eClr;
      mLo = (mLo | loSet) & ~loClr;
      mHi = (mHi | hiSet) & ~hiClr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      chk("R6 flags", flags, mFlag);
      chk("R3 evtPulse", evt, mEvt());
      chk("R8 irq", {31'b0, irq}, {31'b0, |(mFlag & mIe)});
    end
  end

  task automatic drv();
    @(negedge clk);
    #1;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearStrobes();
    fSet = '0; fClr = '0; eSet = '0; eClr = '0;
    loSet = '0; loClr = '0; hiSet = '0; hiClr = '0; fc = '0;
  endtask

  initial begin
    pin = 32'h1;                       // pin0 high through reset (R10)
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    cmpOn = 1;
    @(negedge clk);
    chk("R1 flags", flags, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 evt", evt, 32'h0);
    waitN(6);
    chk("R10 flags", flags, 32'h0);

    // R2: unfiltered latency on pin1
    #1 pin[1] = 1'b1;
    waitN(1); chk("R2 evt early", evt & 32'h2, 32'h0);
    waitN(1); chk("R2 evt", evt & 32'h2, 32'h2);
    waitN(1); chk("R2 flag", flags & 32'h2, 32'h2);
    chk("R7 one-cycle pulse", evt & 32'h2, 32'h0);
    chk("R7 irq off", {31'b0, irq}, 32'h0);

    // R8: enabling raises irq one cycle later
    #1 eSet = 32'h2;
    waitN(1); chk("R8 irq", {31'b0, irq}, 32'h1);
    #1 clearStrobes(); fc = 32'h2;
    waitN(1); chk("R6 cleared", flags & 32'h2, 32'h0);
    #1 clearStrobes();

    // R6: clear in the same cycle as a new edge
    pin[1] = 1'b0;
    waitN(2); chk("R6 evt", evt & 32'h2, 32'h2);
    #1 fc = 32'h2;
    waitN(1); chk("R6 edge beats clear", flags & 32'h2, 32'h2);
    #1 clearStrobes();

    // R9: set and clear together, clear wins
    eSet = 32'h2; eClr = 32'h2;
    waitN(1); chk("R9 clear wins", {31'b0, irq}, 32'h0);
    #1 clearStrobes(); fc = '1;
    drv(); clearStrobes();

    // R4: filter on pin2 drops a one-sample glitch
    fSet = 32'h4;
    drv(); clearStrobes(); pin[2] = 1'b1;
    drv(); pin[2] = 1'b0;
    waitN(8); chk("R4 glitch dropped", flags & 32'h4, 32'h0);
    #1 pin[2] = 1'b1;
    waitN(3); chk("R4 evt early", evt & 32'h4, 32'h0);
    waitN(1); chk("R4 filtered latency", evt & 32'h4, 32'h4);
    #1 fc = '1;
    drv(); clearStrobes();

    // R5: rise-only with filter on pin3
    loSet = 32'h8; fSet = 32'h8;
    drv(); clearStrobes(); pin[3] = 1'b1;
    waitN(8); chk("R5 rise flagged", flags & 32'h8, 32'h8);
    #1 fc = 32'h8;
    drv(); clearStrobes(); pin[3] = 1'b0;
    waitN(8); chk("R5 fall ignored", flags & 32'h8, 32'h0);

    // R3: reserved code on pin3
    #1 hiSet = 32'h8;
    drv(); clearStrobes(); pin[3] = 1'b1;
    drv(); pin[3] = 1'b0;
    drv(); pin[3] = 1'b1;
    waitN(8); chk("R3 reserved quiet", flags & 32'h8, 32'h0);

    // R3: fall-only unfiltered on pin4
    #1 hiSet = 32'h10;
    drv(); clearStrobes(); pin[4] = 1'b1;
    waitN(6); chk("R3 rise ignored", flags & 32'h10, 32'h0);
    #1 pin[4] = 1'b0;
    waitN(4); chk("R3 fall flagged", flags & 32'h10, 32'h10);

    // Random phase, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      drv();
      pin = pin ^ ($urandom & $urandom & $urandom);
      fSet  = (($urandom % 16) == 0) ? $urandom : '0;
      fClr  = (($urandom % 16) == 0) ? $urandom : '0;
      eSet  = (($urandom % 8)  == 0) ? $urandom : '0;
      eClr  = (($urandom % 8)  == 0) ? $urandom : '0;
      loSet = (($urandom % 16) == 0) ? $urandom : '0;
      loClr = (($urandom % 16) == 0) ? $urandom : '0;
      hiSet = (($urandom % 16) == 0) ? $urandom : '0;
      hiClr = (($urandom % 16) == 0) ? $urandom : '0;
      fc    = (($urandom % 4)  == 0) ? $urandom : '0;
    end
    drv(); clearStrobes();
    waitN(4);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule